// File: doc/BRIEF.md
# Instruction Fetch Program-Counter Unit

This block owns the program counter of a single-cycle processor front end. It drives the current PC as the instruction address and returns the instruction word stored at that address in a small internal array. On every falling clock edge it loads the PC for the next cycle. The next PC is either the sequential address or a PC-relative branch target.

Instructions are four bytes wide and the memory is byte addressed, so the sequential successor is PC + 4. The decoder supplies a branch request, the ALU supplies its zero flag, and the current instruction supplies a 16-bit signed word offset. A branch is taken only when the branch request and the zero flag are both set. The target is the sequential address plus the sign-extended offset times four.

The instruction array is a read-only store that is computed at elaboration. Each word is a fixed function of its index, so any fetched word can be predicted from the PC alone.

Top module: `ifetch_unit`

## Requirements
- R1: `instrOut` shows, without a clock, the array word selected by PC bits [ROM_ADDR_W+1:2]. The word at index i equals (i × 0x00010003) XOR 0xA5C30000, truncated to 32 bits.
- R2: When `brSel` is 0, the next PC is PC + 4. This holds for both values of `aluZero` and for any offset.
- R3: When `brSel` is 1 and `aluZero` is 0, the next PC is PC + 4.
- R4: When `brSel` and `aluZero` are both 1, the next PC is PC + 4 + (sign-extended `brOffset` shifted left by 2). This applies to forward branches, where `brOffset` bit 15 is 0.
- R5: A `brOffset` with bit 15 set is a negative word count and moves the PC backward by the same rule.
- R6: Reset is synchronous and is sampled on the falling edge. While `rst` is 1 the PC becomes 0 at each falling edge, whatever the branch inputs are.
- R7: The PC changes only on the falling clock edge. A rising edge leaves `pcOut` unchanged.
- R8: PC arithmetic wraps modulo 2^32, both below zero and past 0xFFFFFFFC.
- R9: PC bits above ROM_ADDR_W+1 take no part in array indexing. PC 0x100 fetches the same word as PC 0 with the default 64-word array.
- R10: The PC always stays a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC loads on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| brSel | input | 1 | Next-PC select: 1 = branch instruction, 0 = sequential |
| aluZero | input | 1 | ALU zero flag (branch condition) |
| brOffset | input | 16 | Signed branch offset in words |
| pcOut | output | 32 | Current PC, used as the instruction address |
| instrOut | output | 32 | Instruction word at the current PC |

## Verification
A wrong PC appears at `pcOut` right after the falling edge that loads it. It also appears on `instrOut` in the same cycle, because the fetched word depends only on the PC. Every later PC is built on the wrong one, so a single bad update shifts every value that follows it. The checks therefore sample just after each falling edge and compare both outputs with a reference PC that steps through forward, backward, not-taken, wrapping and aliasing cases. A state change on the wrong edge shows up only in a sample taken just after the rising edge, so that case gets its own sample.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  // Strobes passed from the control to the datapath for one PC update
  typedef struct packed {
    logic clearPc;     // force PC to zero at this falling edge
    logic pickTarget;  // load branch target instead of PC + step
  } pcStrobe_t;

endpackage

// File: rtl/ifu_ctrl.sv
module ifu_ctrl
  import ifu_pkg::*;
(
  input  logic      rst,
  input  logic      brSel,
  input  logic      aluZero,
  output pcStrobe_t strobe
);

  // Taken only for a branch whose compare came out equal; reset wins
  always_comb begin
    strobe.clearPc    = rst;
    strobe.pickTarget = brSel & aluZero & ~rst;
  end

endmodule

// File: rtl/ifu_datapath.sv
module ifu_datapath
  import ifu_pkg::*;
#(
  parameter int          PC_W        = 32,
  parameter int          OFF_W       = 16,
  parameter int          INSTR_W     = 32,
  parameter int          INSTR_BYTES = 4,
  parameter int          ROM_ADDR_W  = 6,
  parameter logic [31:0] ROM_MUL     = 32'h0001_0003,
  parameter logic [31:0] ROM_SEED    = 32'hA5C3_0000
) (
  input  logic               clk,
  input  pcStrobe_t          strobe,
  input  logic [OFF_W-1:0]   brOffset,
  output logic [PC_W-1:0]    pcOut,
  output logic [INSTR_W-1:0] instrOut
);

  localparam int ALIGN_W   = $clog2(INSTR_BYTES);
  localparam int ROM_DEPTH = 1 << ROM_ADDR_W;
  localparam int IDX_LO    = ALIGN_W;
  localparam int IDX_HI    = ROM_ADDR_W + ALIGN_W - 1;
  localparam int EXT_W     = PC_W - OFF_W - ALIGN_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  logic [PC_W-1:0]    pcReg;
  logic [PC_W-1:0]    seqPc;
  logic [PC_W-1:0]    offBytes;
  logic [PC_W-1:0]    targetPc;
  logic [PC_W-1:0]    nextPc;
  logic [INSTR_W-1:0] romWords [ROM_DEPTH];

  // Read-only instruction store, one word per index, computed at elaboration
  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    assign romWords[g] = (INSTR_W'(g) * INSTR_W'(ROM_MUL)) ^ INSTR_W'(ROM_SEED);
  end

  // Next-address arithmetic
  assign seqPc    = pcReg + STEP;
  assign offBytes = {{EXT_W{brOffset[OFF_W-1]}}, brOffset, {ALIGN_W{1'b0}}};
  assign targetPc = seqPc + offBytes;
  assign nextPc   = strobe.pickTarget ? targetPc : seqPc;

  // PC register, falling-edge loaded
  always_ff @(negedge clk) begin
    if (strobe.clearPc) pcReg <= '0;
    else                pcReg <= nextPc;
  end

  assign pcOut    = pcReg;
  assign instrOut = romWords[pcReg[IDX_HI:IDX_LO]];

  // R6: reset drives the PC to zero at the next falling edge
  p_reset_zero_r6: assert property (@(negedge clk)
    strobe.clearPc |=> (pcOut == '0));

  // R4 and R5: a taken branch moves the PC by one step plus the scaled signed offset
  p_taken_target_r4: assert property (@(negedge clk) disable iff (strobe.clearPc)
    strobe.pickTarget |=>
      ((pcOut - $past(pcOut)) == (STEP + (PC_W'(signed'($past(brOffset))) << ALIGN_W))));

  // R10: the PC never leaves word alignment
  p_aligned_r10: assert property (@(negedge clk) disable iff (strobe.clearPc)
    pcOut[ALIGN_W-1:0] == '0);

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifu_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int OFF_W      = 16,
  parameter int INSTR_W    = 32,
  parameter int ROM_ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               brSel,
  input  logic               aluZero,
  input  logic [OFF_W-1:0]   brOffset,
  output logic [PC_W-1:0]    pcOut,
  output logic [INSTR_W-1:0] instrOut
);

  localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(4);

  pcStrobe_t strobe;

  ifu_ctrl u_ctrl (
    .rst     (rst),
    .brSel   (brSel),
    .aluZero (aluZero),
    .strobe  (strobe)
  );

  ifu_datapath #(
    .PC_W        (PC_W),
    .OFF_W       (OFF_W),
    .INSTR_W     (INSTR_W),
    .INSTR_BYTES (4),
    .ROM_ADDR_W  (ROM_ADDR_W)
  ) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .brOffset (brOffset),
    .pcOut    (pcOut),
    .instrOut (instrOut)
  );

  // R2: a non-branch instruction steps sequentially whatever the zero flag says
  p_seq_step_r2: assert property (@(negedge clk) disable iff (rst)
    !brSel |=> (pcOut == $past(pcOut) + SEQ_STEP));

  // R3: a branch whose compare failed also steps sequentially
  p_not_taken_r3: assert property (@(negedge clk) disable iff (rst)
    (brSel && !aluZero) |=> (pcOut == $past(pcOut) + SEQ_STEP));

endmodule

// File: tb/tb_ifetch_unit.sv
`timescale 1ns/1ps
module tb_ifetch_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        brSel = 1'b0;
  logic        aluZero = 1'b0;
  logic [15:0] brOffset = '0;
  logic [31:0] pcOut;
  logic [31:0] instrOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  ifetch_unit dut (
    .clk      (clk),
    .rst      (rst),
    .brSel    (brSel),
    .aluZero  (aluZero),
    .brOffset (brOffset),
    .pcOut    (pcOut),
    .instrOut (instrOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Stimulus vectors {brSel, aluZero, brOffset}, applied from PC 0
  localparam logic [17:0] VEC [10] = '{
    {1'b0, 1'b0, 16'h0000},  // R2
    {1'b0, 1'b1, 16'h0064},  // R2 zero ignored
    {1'b1, 1'b0, 16'h0005},  // R3
    {1'b1, 1'b1, 16'h0003},  // R4 forward
    {1'b1, 1'b1, 16'hFFFC},  // R5 backward
    {1'b0, 1'b0, 16'h7FFF},  // R2
    {1'b1, 1'b1, 16'h0010},  // R4 forward
    {1'b1, 1'b1, 16'hFFF0},  // R5 backward
    {1'b1, 1'b0, 16'h8000},  // R3
    {1'b1, 1'b1, 16'h0000}   // R4 zero offset
  };

  function automatic logic [31:0] wordAt(input logic [31:0] pc);
    logic [31:0] idx;
    idx = {26'd0, pc[7:2]};
    return (idx * 32'h0001_0003) ^ 32'hA5C3_0000;
  endfunction

  function automatic logic [31:0] refNext(input logic [31:0] pc, input logic s,
                                          input logic z, input logic [15:0] off);
    logic [31:0] disp;
    disp = 32'(signed'(off)) * 32'd4;
    if (s && z) return pc + 32'd4 + disp;
    return pc + 32'd4;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic z, input logic [15:0] off);
    brSel = s; aluZero = z; brOffset = off;
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] expPc;
    logic [31:0] held;

    // R6: reset state
    @(negedge clk); @(negedge clk); #1;
    check("R6 reset pc", pcOut, 32'h0);
    check("R1 reset instr", instrOut, wordAt(32'h0));
    rst = 1'b0;
    expPc = 32'h0;

    // Table walk, R1..R5
    for (int i = 0; i < 10; i++) begin
      expPc = refNext(expPc, VEC[i][17], VEC[i][16], VEC[i][15:0]);
      step(VEC[i][17], VEC[i][16], VEC[i][15:0]);
      check($sformatf("R2-5 vec%0d pc", i), pcOut, expPc);
      check($sformatf("R1 vec%0d instr", i), instrOut, wordAt(expPc));
      check("R10 align", {30'd0, pcOut[1:0]}, 32'h0);
    end

    // R7: rising edge must not move the PC
    brSel = 1'b0; aluZero = 1'b0;
    held = pcOut;
    @(posedge clk); #1;
    check("R7 rising edge hold", pcOut, held);
    @(negedge clk); #1;
    check("R7 falling edge load", pcOut, held + 32'd4);

    // R6: reset mid-run overrides a taken branch
    rst = 1'b1; brSel = 1'b1; aluZero = 1'b1; brOffset = 16'h0040;
    @(negedge clk); #1;
    check("R6 reset beats branch", pcOut, 32'h0);
    rst = 1'b0;

    // R8: wrap below zero, then past the top
    step(1'b1, 1'b1, 16'hFFFE);
    check("R8 wrap below zero", pcOut, 32'hFFFF_FFFC);
    check("R1 top instr", instrOut, wordAt(32'hFFFF_FFFC));
    step(1'b0, 1'b0, 16'h0000);
    check("R8 wrap past top", pcOut, 32'h0);

    // R9: high PC bits do not index the array
    step(1'b1, 1'b1, 16'h003F);
    check("R9 alias pc", pcOut, 32'h0000_0100);
    check("R9 alias instr", instrOut, wordAt(32'h0));

    // R3: not-taken with a negative offset stays sequential
    step(1'b1, 1'b0, 16'hFFFF);
    check("R3 not taken negative", pcOut, 32'h0000_0104);

    // R5: largest backward branch
    step(1'b1, 1'b1, 16'h8000);
    check("R5 max backward", pcOut, 32'h0000_0108 - 32'h0002_0000);

    finish_run();
  end

endmodule